// File: doc/BRIEF.md
# Multi-Source Reset and Start-up Sequencer

This block sequences reset for a small system made of a microcontroller and a DSP. Three causes start a system reset: an active-high external reset pin, expiry of the internal watchdog, and a wake-up interrupt that ends the system-off state. Every cause leads to the same hold phase. In that phase the microcontroller reset is held for a counted start-up delay, so that its first instruction fetch always comes at least `FETCH_DELAY` clock cycles after the cause has cleared. The DSP reset is released separately. It stays asserted until software sets a DSP enable bit, and it is released a fixed `DSP_LAG` cycles after that bit is set. This spreads out the reset power surge.

The controller is a three-state machine. HOLD counts the start-up delay. RUN is normal operation. OFF is the system-off state, in which the clock enable for the rest of the chip is low. The transitions are: HOLD to RUN when the delay counter reaches its last value with the pin released. RUN to HOLD on the pin or on watchdog expiry. RUN to OFF on a software off request. OFF to HOLD on the pin or on a rising edge of the wake interrupt. Any other state returns to HOLD. A one-hot cause register holds the source of the most recent reset and clears when it is read. The watchdog is a 16-bit down-counter with a software reload value and a kick strobe.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_n` is low, `mcu_rst` and `dsp_rst` are 1, `cause` is 0 and `clk_en` is 1. After `por_n` rises, `mcu_rst` stays 1 for exactly `FETCH_DELAY` (4096) rising edges.
- R2: A 1 on `ext_rst_pin` drives `mcu_rst` and `dsp_rst` to 1 at once, without waiting for a clock edge.
- R3: After `ext_rst_pin` returns to 0, `mcu_rst` stays 1 for at least `FETCH_DELAY` and at most `FETCH_DELAY`+3 cycles. The pin passes through a two-flop synchronizer.
- R4: A `wdg_kick` loads the 16-bit watchdog counter from the reload register. In RUN, with no further kick, `mcu_rst` rises R+1 cycles after the kick edge, where R is the reload value. It then stays 1 for exactly `FETCH_DELAY` cycles.
- R5: Kicks that arrive before the counter reaches zero prevent any watchdog reset.
- R6: Watchdog expiry is a pulse that lasts exactly one cycle.
- R7: `off_req` in RUN moves to OFF. In OFF, `clk_en` is 0 and both resets are 1 until the pin or a wake edge arrives.
- R8: A rising edge of `wake_irq` in OFF starts a reset. `mcu_rst` then stays 1 for `FETCH_DELAY` to `FETCH_DELAY`+4 cycles after the wake input rises, and `clk_en` returns to 1. Outside OFF, `wake_irq` has no effect.
- R9: `cause` is one-hot: bit 0 is pin, bit 1 is watchdog, bit 2 is wake. Each new reset event overwrites it, with priority pin, then watchdog, then wake.
- R10: A one-cycle `cause_rd` clears `cause` to 0 on the next edge.
- R11: The DSP enable bit is 0 after power-on and after every system reset, and writes to it are taken only in RUN. While the bit is 0, `dsp_rst` is 1.
- R12: `dsp_rst` falls exactly `DSP_LAG` (16) edges after the edge that writes enable = 1, and never while `mcu_rst` is 1. Writing enable = 0 asserts `dsp_rst` again after that edge.
- R13: The watchdog counter is frozen outside RUN, so it cannot expire in HOLD or OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| por_n | input | 1 | Asynchronous power-on reset of the controller, active low |
| ext_rst_pin | input | 1 | External reset request, active high, asynchronous |
| wake_irq | input | 1 | External wake interrupt, asynchronous |
| off_req | input | 1 | Software request to enter system-off |
| wdg_kick | input | 1 | Watchdog restart strobe |
| wdg_reload_we | input | 1 | Write strobe for the watchdog reload value |
| wdg_reload_val | input | 16 | New watchdog reload value |
| dsp_en_we | input | 1 | Write strobe for the DSP enable bit |
| dsp_en_val | input | 1 | Value written to the DSP enable bit |
| cause_rd | input | 1 | Read strobe; clears the cause register |
| mcu_rst | output | 1 | Microcontroller reset, active high |
| dsp_rst | output | 1 | DSP reset, active high |
| clk_en | output | 1 | System clock enable, low in system-off |
| cause | output | 3 | One-hot cause of the latest reset |

## Verification
The start-up delay is tried with each of the three causes and with power-on. Exact cycle counts for power-on and the watchdog show that the counter starts from zero with no synchronizer delay in the path. The range checks for the pin and wake cases show that the two-flop stage is present and that the delay restarts only after release. A table of watchdog reload values shows that the expiry point follows the reload register and not a fixed count. Sequences of kicks, a wake pulse during RUN, and enable writes made during HOLD each separate "ignored" from "acted on".

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_RUN  = 2'd1,
        ST_OFF  = 2'd2
    } seq_state_e;

    localparam int CAUSE_W    = 3;
    localparam int CAUSE_PIN  = 0;
    localparam int CAUSE_WDG  = 1;
    localparam int CAUSE_WAKE = 2;

    typedef logic [CAUSE_W-1:0] cause_t;

endpackage

// File: rtl/rst_sync2.sv
module rst_sync2 #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
                stage1[i] <= 1'b0;
                stage2[i] <= 1'b0;
            end else begin
                stage1[i] <= d[i];
                stage2[i] <= stage1[i];
            end
        end
    end

    assign q = stage2;
endmodule

// File: rtl/rst_wdg_timer.sv
module rst_wdg_timer #(
    parameter int          CNT_W       = 16,
    parameter logic [15:0] RELOAD_INIT = 16'hFFFF
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             run,
    input  logic             kick,
    input  logic             reload_we,
    input  logic [CNT_W-1:0] reload_val,
    output logic             expire
);
    localparam logic [CNT_W-1:0] INIT_V = CNT_W'(RELOAD_INIT);

    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            reload_q <= INIT_V;
        end else if (reload_we) begin
            reload_q <= reload_val;
        end
    end

    // Frozen at the reload value whenever the system is not running.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= INIT_V;
        end else if (!run || kick) begin
            cnt_q <= reload_q;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expire = run && !kick && (cnt_q == '0);
endmodule

// File: rtl/rst_dsp_gate.sv
module rst_dsp_gate #(
    parameter int DSP_LAG = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic run,
    input  logic en_we,
    input  logic en_val,
    output logic dsp_en,
    output logic dsp_hold
);
    localparam int           LW    = $clog2(DSP_LAG + 1);
    localparam logic [LW-1:0] LAG_V = LW'(DSP_LAG);

    logic          en_q;
    logic [LW-1:0] lag_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            en_q <= 1'b0;
        end else if (!run) begin
            en_q <= 1'b0;
        end else if (en_we) begin
            en_q <= en_val;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            lag_q <= '0;
        end else if (!en_q || !run) begin
            lag_q <= '0;
        end else if (lag_q != LAG_V) begin
            lag_q <= lag_q + LW'(1);
        end
    end

    assign dsp_en   = en_q;
    assign dsp_hold = !run || !en_q || (lag_q != LAG_V);
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import rst_seq_pkg::*;
#(
    parameter int FETCH_DELAY = 4096
) (
    input  logic   clk,
    input  logic   por_n,
    input  logic   pin_s,
    input  logic   wake_s,
    input  logic   wdg_exp,
    input  logic   off_req,
    input  logic   cause_rd,
    output logic   mcu_hold,
    output logic   clk_en_q,
    output logic   run,
    output cause_t cause_q
);
    localparam int            CW   = $clog2(FETCH_DELAY);
    localparam logic [CW-1:0] LAST = CW'(FETCH_DELAY - 1);

    seq_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          wake_prev_q;
    logic          wake_rise;
    cause_t        ev;

    assign wake_rise = wake_s && !wake_prev_q;

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q     <= ST_HOLD;
            cnt_q       <= '0;
            wake_prev_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            cnt_q       <= cnt_d;
            wake_prev_q <= wake_s;
        end
    end

    // Next state, delay counter and reset events
    always_comb begin
        state_d = state_q;
        ev      = '0;
        unique case (state_q)
            ST_HOLD: begin
                if (pin_s) begin
                    ev[CAUSE_PIN] = 1'b1;
                end else if (cnt_q == LAST) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (pin_s) begin
                    state_d        = ST_HOLD;
                    ev[CAUSE_PIN]  = 1'b1;
                end else if (wdg_exp) begin
                    state_d        = ST_HOLD;
                    ev[CAUSE_WDG]  = 1'b1;
                end else if (off_req) begin
                    state_d        = ST_OFF;
                end
            end
            ST_OFF: begin
                if (pin_s) begin
                    state_d        = ST_HOLD;
                    ev[CAUSE_PIN]  = 1'b1;
                end else if (wake_rise) begin
                    state_d        = ST_HOLD;
                    ev[CAUSE_WAKE] = 1'b1;
                end
            end
            default: state_d = ST_HOLD;
        endcase

        if (state_q == ST_HOLD && state_d == ST_HOLD && !pin_s) begin
            cnt_d = cnt_q + CW'(1);
        end else begin
            cnt_d = '0;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            mcu_hold <= 1'b1;
            clk_en_q <= 1'b1;
            cause_q  <= '0;
        end else begin
            mcu_hold <= (state_d != ST_RUN);
            clk_en_q <= (state_d != ST_OFF);
            if (ev != '0) begin
                cause_q <= ev;
            end else if (cause_rd) begin
                cause_q <= '0;
            end
        end
    end

    assign run = (state_q == ST_RUN);
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int          FETCH_DELAY = 4096,
    parameter int          DSP_LAG     = 16,
    parameter int          WDG_W       = 16,
    parameter logic [15:0] WDG_INIT    = 16'hFFFF
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               ext_rst_pin,
    input  logic               wake_irq,
    input  logic               off_req,
    input  logic               wdg_kick,
    input  logic               wdg_reload_we,
    input  logic [WDG_W-1:0]   wdg_reload_val,
    input  logic               dsp_en_we,
    input  logic               dsp_en_val,
    input  logic               cause_rd,
    output logic               mcu_rst,
    output logic               dsp_rst,
    output logic               clk_en,
    output logic [CAUSE_W-1:0] cause
);
    logic [1:0] async_in;
    logic [1:0] sync_out;
    logic       pin_s;
    logic       wake_s;
    logic       wdg_exp;
    logic       mcu_hold;
    logic       run;
    logic       dsp_en;
    logic       dsp_hold;
    cause_t     cause_q;

    assign async_in = {wake_irq, ext_rst_pin};
    assign pin_s    = sync_out[0];
    assign wake_s   = sync_out[1];

    rst_sync2 #(.WIDTH(2)) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .d     (async_in),
        .q     (sync_out)
    );

    rst_seq_fsm #(.FETCH_DELAY(FETCH_DELAY)) u_fsm (
        .clk      (clk),
        .por_n    (por_n),
        .pin_s    (pin_s),
        .wake_s   (wake_s),
        .wdg_exp  (wdg_exp),
        .off_req  (off_req),
        .cause_rd (cause_rd),
        .mcu_hold (mcu_hold),
        .clk_en_q (clk_en),
        .run      (run),
        .cause_q  (cause_q)
    );

    rst_wdg_timer #(.CNT_W(WDG_W), .RELOAD_INIT(WDG_INIT)) u_wdg (
        .clk        (clk),
        .por_n      (por_n),
        .run        (run),
        .kick       (wdg_kick),
        .reload_we  (wdg_reload_we),
        .reload_val (wdg_reload_val),
        .expire     (wdg_exp)
    );

    rst_dsp_gate #(.DSP_LAG(DSP_LAG)) u_dsp (
        .clk      (clk),
        .por_n    (por_n),
        .run      (run),
        .en_we    (dsp_en_we),
        .en_val   (dsp_en_val),
        .dsp_en   (dsp_en),
        .dsp_hold (dsp_hold)
    );

    // Asserted at once by the raw pin, released only from registered state.
    assign mcu_rst = mcu_hold | ext_rst_pin;
    assign dsp_rst = dsp_hold | ext_rst_pin;
    assign cause   = cause_q;
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
    parameter int FETCH_DELAY = 4096
) (
    input logic       clk,
    input logic       por_n,
    input logic       mcu_rst,
    input logic       mcu_hold,
    input logic       dsp_rst,
    input logic       clk_en,
    input logic       wdg_exp,
    input logic       dsp_en,
    input logic [2:0] cause
);
    int hcnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            hcnt <= 0;
        end else if (mcu_rst) begin
            if (hcnt < FETCH_DELAY + 8) hcnt <= hcnt + 1;
        end else begin
            hcnt <= 0;
        end
    end

    p_hold_len_r3: assert property (@(posedge clk) disable iff (!por_n)
        $fell(mcu_rst) |-> (hcnt >= FETCH_DELAY));

    p_exp_resets_r4: assert property (@(posedge clk) disable iff (!por_n)
        wdg_exp |=> mcu_rst);

    p_exp_pulse_r6: assert property (@(posedge clk) disable iff (!por_n)
        wdg_exp |=> !wdg_exp);

    p_off_held_r7: assert property (@(posedge clk) disable iff (!por_n)
        !clk_en |-> (mcu_rst && dsp_rst));

    p_cause_onehot_r9: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0(cause));

    p_en_cleared_r11: assert property (@(posedge clk) disable iff (!por_n)
        mcu_hold |=> !dsp_en);

    p_dsp_order_r12: assert property (@(posedge clk) disable iff (!por_n)
        mcu_rst |-> dsp_rst);
endmodule

bind rst_seq_ctrl rst_seq_chk #(.FETCH_DELAY(FETCH_DELAY)) u_chk (
    .clk      (clk),
    .por_n    (por_n),
    .mcu_rst  (mcu_rst),
    .mcu_hold (mcu_hold),
    .dsp_rst  (dsp_rst),
    .clk_en   (clk_en),
    .wdg_exp  (wdg_exp),
    .dsp_en   (dsp_en),
    .cause    (cause)
);

// File: tb/rst_seq_ctrl_tb.sv
module rst_seq_ctrl_tb;
    localparam int DLY = 4096;
    localparam int LAG = 16;
    localparam int NV  = 4;
    localparam logic [15:0] RL_TAB  [NV] = '{16'd5, 16'd37, 16'd200, 16'd12};
    localparam int          LOW_TAB [NV] = '{6, 38, 201, 13};

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        ext_rst_pin = 1'b0;
    logic        wake_irq = 1'b0;
    logic        off_req = 1'b0;
    logic        wdg_kick = 1'b0;
    logic        wdg_reload_we = 1'b0;
    logic [15:0] wdg_reload_val = '0;
    logic        dsp_en_we = 1'b0;
    logic        dsp_en_val = 1'b0;
    logic        cause_rd = 1'b0;
    logic        mcu_rst, dsp_rst, clk_en;
    logic [2:0]  cause;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rst_seq_ctrl u_dut (
        .clk(clk), .por_n(por_n), .ext_rst_pin(ext_rst_pin), .wake_irq(wake_irq),
        .off_req(off_req), .wdg_kick(wdg_kick), .wdg_reload_we(wdg_reload_we),
        .wdg_reload_val(wdg_reload_val), .dsp_en_we(dsp_en_we), .dsp_en_val(dsp_en_val),
        .cause_rd(cause_rd), .mcu_rst(mcu_rst), .dsp_rst(dsp_rst), .clk_en(clk_en),
        .cause(cause)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic count_high(output int n);
        n = 0;
        while (mcu_rst === 1'b1 && n < 20000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic set_reload(input logic [15:0] v);
        wdg_reload_we = 1'b1; wdg_reload_val = v;
        @(negedge clk);
        wdg_reload_we = 1'b0;
        wdg_kick = 1'b1;
        @(negedge clk);
        wdg_kick = 1'b0;
    endtask

    task automatic dsp_write(input logic v);
        dsp_en_we = 1'b1; dsp_en_val = v;
        @(negedge clk);
        dsp_en_we = 1'b0;
    endtask

    task automatic read_cause();
        cause_rd = 1'b1;
        @(negedge clk);
        cause_rd = 1'b0;
    endtask

    initial begin
        int n;
        bit seen;
        ticks(3);
        check(mcu_rst && dsp_rst && clk_en && cause == 3'b000, "R1 reset state",
              {mcu_rst, dsp_rst, clk_en, cause}, 32'b111000);
        por_n = 1'b1;
        count_high(n);
        check(n == DLY, "R1 power-on hold length", n, DLY);

        // R11: DSP stays in reset while disabled
        ticks(5);
        check(dsp_rst == 1'b1, "R11 dsp held while disabled", dsp_rst, 1);
        // R12: release lag
        dsp_write(1'b1);
        n = 0;
        while (dsp_rst === 1'b1 && n < 100) begin n++; @(negedge clk); end
        check(n == LAG, "R12 dsp release lag", n, LAG);
        dsp_write(1'b0);
        check(dsp_rst == 1'b1, "R12 dsp re-asserted on disable", dsp_rst, 1);
        dsp_write(1'b1);
        ticks(LAG + 2);

        // Vector table: watchdog reload -> cycles to reset (R4, R9, R11)
        for (int i = 0; i < NV; i++) begin
            set_reload(RL_TAB[i]);
            n = 0;
            while (mcu_rst === 1'b0 && n < 1000) begin n++; @(negedge clk); end
            check(n == LOW_TAB[i], "R4 expiry point", n, LOW_TAB[i]);
            check(cause == 3'b010, "R9 watchdog cause", cause, 2);
            check(dsp_rst == 1'b1, "R11 dsp reset with system", dsp_rst, 1);
            if (i == 0) dsp_write(1'b1);
            else @(negedge clk);
            count_high(n);
            check(n == DLY - 1, "R4 hold after watchdog", n + 1, DLY);
        end
        set_reload(16'hFFFF);
        ticks(LAG + 4);
        check(dsp_rst == 1'b1, "R11 enable cleared and HOLD write ignored", dsp_rst, 1);

        // R10: clear on read
        read_cause();
        check(cause == 3'b000, "R10 cleared by read", cause, 0);

        // R5: regular kicks keep the system running
        set_reload(16'd40);
        seen = 1'b0;
        for (int k = 0; k < 10; k++) begin
            for (int j = 0; j < 30; j++) begin
                @(negedge clk);
                if (mcu_rst) seen = 1'b1;
            end
            wdg_kick = 1'b1;
            @(negedge clk);
            wdg_kick = 1'b0;
        end
        check(!seen, "R5 kicks prevent expiry", seen, 0);
        set_reload(16'hFFFF);

        // R8: wake in RUN ignored
        wake_irq = 1'b1;
        ticks(5);
        wake_irq = 1'b0;
        ticks(5);
        check(mcu_rst == 1'b0 && cause == 3'b000, "R8 wake ignored in RUN",
              {mcu_rst, cause}, 0);

        // R2/R3: external pin
        dsp_write(1'b1);
        ticks(LAG + 2);
        check(dsp_rst == 1'b0, "R12 dsp running before pin", dsp_rst, 0);
        ext_rst_pin = 1'b1;
        #1;
        check(mcu_rst && dsp_rst, "R2 asynchronous assertion", {mcu_rst, dsp_rst}, 3);
        ticks(10);
        ext_rst_pin = 1'b0;
        count_high(n);
        check(n >= DLY && n <= DLY + 3, "R3 hold after pin", n, DLY + 2);
        check(cause == 3'b001, "R9 pin cause", cause, 1);

        // R7/R13/R8: system-off and wake
        read_cause();
        set_reload(16'd20);
        off_req = 1'b1;
        @(negedge clk);
        off_req = 1'b0;
        check(clk_en == 1'b0 && mcu_rst && dsp_rst, "R7 system-off entered",
              {clk_en, mcu_rst, dsp_rst}, 3);
        ticks(100);
        check(clk_en == 1'b0 && mcu_rst, "R7 stays off", {clk_en, mcu_rst}, 1);
        check(cause == 3'b000, "R13 watchdog frozen in OFF", cause, 0);
        wake_irq = 1'b1;
        count_high(n);
        wake_irq = 1'b0;
        check(n >= DLY && n <= DLY + 4, "R8 hold after wake", n, DLY + 3);
        check(cause == 3'b100 && clk_en == 1'b1, "R8 wake cause and clock", {clk_en, cause}, 12);
        set_reload(16'hFFFF);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule